// File: doc/BRIEF.md
# Audio Interface Interrupt and Frame-Match Unit

This block collects the interrupt events of an audio serial interface into one control word and drives a single level-sensitive interrupt line. There are eight event sources. Each has an enable bit and a pending bit, and the two bits sit next to each other in the upper half of a 32-bit control register. Seven sources arrive as one-cycle pulses from neighbouring interface logic. The eighth comes from a free-running frame counter that is compared against a programmable match value.

Software reaches the block through a simple register port with byte addresses on a 16-byte stride inside a 256-byte window. It enables sources and acknowledges events by writing 1 to their pending bits. It reads the frame count and reprograms the match value to schedule the next frame-count interrupt.

Top module: `irqFrameUnit`

## Requirements
- R1: After reset the control register, frame count and match value all read as zero, and `irqOut` is low.
- R2: Source k (k = 0..7) has its enable bit at control-register bit 17+2k and its pending bit at bit 16+2k. Sources 0..6 are fed by `evtIn[k]`. Source 7 (bits 31/30) is the frame-match event. Bits 15..0 always read 0, and writes to them have no effect.
- R3: A pulse on a source sets its pending bit at the next clock edge, whether or not that source is enabled.
- R4: A write to the control register (offset 0x00) loads every enable bit from the written data. A 1 written to a pending bit clears it, and a 0 leaves it unchanged.
- R5: If a source event and a write of 1 to the same pending bit occur in the same cycle, the pending bit ends up set.
- R6: `irqOut` is a registered OR, over all sources, of pending AND enable. It goes high one cycle after the condition is true and stays high until no enabled source is pending.
- R7: The frame counter (read at offset 0x40) increments by one on each cycle in which `frameStrobe` is high. It wraps from its maximum value to zero and holds its value otherwise.
- R8: The match value is read and written at offset 0x50, and only its low CNT_W bits are stored. The frame-match pending bit is set only by a strobe that makes the counter equal to the match value. The following do not set it: writing a match value equal to the current count, and idle cycles while the two stay equal.
- R9: The following addresses read as 0, and writes to them have no effect: any address that is not 16-byte aligned, and any aligned address other than 0x00, 0x40 and 0x50. Writes to 0x40 have no effect on the counter.
- R10: `regRdData` is loaded at the clock edge where `regRdEn` is high, so the value is available one cycle after the request. It holds its value while `regRdEn` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| frameStrobe | input | 1 | One-cycle pulse per audio frame |
| evtIn | input | NUM_SRC-1 | One-cycle event pulses for sources 0..6 |
| regAddr | input | ADDR_W | Byte address of the register access |
| regWrEn | input | 1 | Write request |
| regWrData | input | DATA_W | Write data |
| regRdEn | input | 1 | Read request |
| regRdData | output | DATA_W | Registered read data |
| irqOut | output | 1 | Level interrupt request |

## Verification
An event pulse or a matching strobe becomes visible in its pending bit at the same edge that samples it. `irqOut` follows one edge later, and so does any write that enables or acknowledges a source. A read returns data one edge after its request. The bench drives every stimulus at a falling edge and returns from each task at the falling edge that follows the effective rising edge. Checks on `irqOut` wait one further falling edge, so each sample lands exactly in the cycle where the result is due. The counter is built 4 bits wide so that wrap-around and repeated matches are swept fully within a short run.

// File: rtl/irqUnitPkg.sv
package irqUnitPkg;

  // register slots: byte address bits above the 16-byte stride
  localparam int SLOT_SHIFT = 4;
  localparam int CTRL_SLOT  = 0;
  localparam int COUNT_SLOT = 4;
  localparam int MATCH_SLOT = 5;

  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_CTRL,
    SEL_COUNT,
    SEL_MATCH
  } regSel_e;

  typedef struct packed {
    logic    wrCtrl;
    logic    wrMatch;
    logic    rdEn;
    regSel_e rdSel;
  } ctrlStrobes_t;

endpackage

// File: rtl/irqControl.sv
module irqControl
  import irqUnitPkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic              regRdEn,
  output ctrlStrobes_t      strobes
);

  localparam int SLOT_W = ADDR_W - SLOT_SHIFT;

  logic              aligned;
  logic [SLOT_W-1:0] slot;
  regSel_e           sel;

  always_comb begin
    aligned = (regAddr[SLOT_SHIFT-1:0] == '0);
    slot    = regAddr[ADDR_W-1:SLOT_SHIFT];
    sel     = SEL_NONE;
    if (aligned) begin
      if (slot == SLOT_W'(CTRL_SLOT))       sel = SEL_CTRL;
      else if (slot == SLOT_W'(COUNT_SLOT)) sel = SEL_COUNT;
      else if (slot == SLOT_W'(MATCH_SLOT)) sel = SEL_MATCH;
    end
  end

  always_comb begin
    strobes.wrCtrl  = regWrEn && (sel == SEL_CTRL);
    strobes.wrMatch = regWrEn && (sel == SEL_MATCH);
    strobes.rdEn    = regRdEn;
    strobes.rdSel   = sel;
  end

endmodule

// File: rtl/irqDatapath.sv
module irqDatapath
  import irqUnitPkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int NUM_SRC = 8,
  parameter int CNT_W   = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobes_t       strobes,
  input  logic [DATA_W-1:0]  wrData,
  input  logic               frameStrobe,
  input  logic [NUM_SRC-2:0] evtIn,
  output logic [DATA_W-1:0]  rdData,
  output logic               irqOut,
  output logic [NUM_SRC-1:0] enVec,
  output logic [NUM_SRC-1:0] pendVec,
  output logic [CNT_W-1:0]   frameCnt
);

  localparam int PAIR_BASE = DATA_W - 2 * NUM_SRC;

  logic [CNT_W-1:0]   matchVal;
  logic [CNT_W-1:0]   cntNext;
  logic               matchHit;
  logic [NUM_SRC-1:0] srcSet;
  logic [DATA_W-1:0]  ctrlImage;
  logic               unusedLowBits;

  assign cntNext       = frameCnt + CNT_W'(1);
  assign matchHit      = frameStrobe && (cntNext == matchVal);
  assign srcSet        = {matchHit, evtIn};
  assign unusedLowBits = ^wrData[PAIR_BASE-1:0];

  // one enable/pending pair per source; a set event outranks a clear
  generate
    for (genvar k = 0; k < NUM_SRC; k++) begin : gSrc
      always_ff @(posedge clk) begin
        if (!rstN) begin
          enVec[k]   <= 1'b0;
          pendVec[k] <= 1'b0;
        end else begin
          if (strobes.wrCtrl) enVec[k] <= wrData[PAIR_BASE + 2*k + 1];
          if (srcSet[k]) pendVec[k] <= 1'b1;
          else if (strobes.wrCtrl && wrData[PAIR_BASE + 2*k]) pendVec[k] <= 1'b0;
        end
      end
    end
  endgenerate

  always_comb begin
    ctrlImage = '0;
    for (int k = 0; k < NUM_SRC; k++) begin
      ctrlImage[PAIR_BASE + 2*k + 1] = enVec[k];
      ctrlImage[PAIR_BASE + 2*k]     = pendVec[k];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) frameCnt <= '0;
    else if (frameStrobe) frameCnt <= cntNext;
  end

  always_ff @(posedge clk) begin
    if (!rstN) matchVal <= '0;
    else if (strobes.wrMatch) matchVal <= wrData[CNT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdData <= '0;
    end else if (strobes.rdEn) begin
      case (strobes.rdSel)
        SEL_CTRL:  rdData <= ctrlImage;
        SEL_COUNT: rdData <= DATA_W'(frameCnt);
        SEL_MATCH: rdData <= DATA_W'(matchVal);
        default:   rdData <= '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) irqOut <= 1'b0;
    else       irqOut <= |(enVec & pendVec);
  end

endmodule

// File: rtl/irqFrameUnit.sv
module irqFrameUnit
  import irqUnitPkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32,
  parameter int NUM_SRC = 8,
  parameter int CNT_W   = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               frameStrobe,
  input  logic [NUM_SRC-2:0] evtIn,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic               regWrEn,
  input  logic [DATA_W-1:0]  regWrData,
  input  logic               regRdEn,
  output logic [DATA_W-1:0]  regRdData,
  output logic               irqOut
);

  ctrlStrobes_t       strobes;
  logic [NUM_SRC-1:0] enVec;
  logic [NUM_SRC-1:0] pendVec;
  logic [CNT_W-1:0]   frameCnt;

  irqControl #(.ADDR_W(ADDR_W)) uControl (
    .regAddr (regAddr),
    .regWrEn (regWrEn),
    .regRdEn (regRdEn),
    .strobes (strobes)
  );

  irqDatapath #(
    .DATA_W  (DATA_W),
    .NUM_SRC (NUM_SRC),
    .CNT_W   (CNT_W)
  ) uDatapath (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .wrData      (regWrData),
    .frameStrobe (frameStrobe),
    .evtIn       (evtIn),
    .rdData      (regRdData),
    .irqOut      (irqOut),
    .enVec       (enVec),
    .pendVec     (pendVec),
    .frameCnt    (frameCnt)
  );

endmodule

// File: rtl/irqUnitChecker.sv
module irqUnitChecker
  import irqUnitPkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32,
  parameter int NUM_SRC = 8,
  parameter int CNT_W   = 32
) (
  input logic               clk,
  input logic               rstN,
  input logic               frameStrobe,
  input logic [NUM_SRC-2:0] evtIn,
  input logic [ADDR_W-1:0]  regAddr,
  input logic               regRdEn,
  input logic [DATA_W-1:0]  regRdData,
  input logic               irqOut,
  input logic [NUM_SRC-1:0] enVec,
  input logic [NUM_SRC-1:0] pendVec,
  input logic [CNT_W-1:0]   frameCnt
);

  localparam int SLOT_W = ADDR_W - SLOT_SHIFT;

  logic              knownAddr;
  logic [SLOT_W-1:0] slot;

  always_comb begin
    slot      = regAddr[ADDR_W-1:SLOT_SHIFT];
    knownAddr = (regAddr[SLOT_SHIFT-1:0] == '0) &&
                (slot == SLOT_W'(CTRL_SLOT) || slot == SLOT_W'(COUNT_SLOT) ||
                 slot == SLOT_W'(MATCH_SLOT));
  end

  // R3 R5
  event_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|evtIn) |=> ((pendVec[NUM_SRC-2:0] & $past(evtIn)) == $past(evtIn)));

  // R6
  irq_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((enVec & pendVec) != '0) |=> irqOut);

  // R6
  irq_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((enVec & pendVec) == '0) |=> !irqOut);

  // R7
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    frameStrobe |=> (frameCnt == CNT_W'($past(frameCnt) + CNT_W'(1))));

  // R7
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !frameStrobe |=> $stable(frameCnt));

  // R9
  unused_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regRdEn && !knownAddr) |=> (regRdData == '0));

  // R10
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !regRdEn |=> $stable(regRdData));

endmodule

bind irqFrameUnit irqUnitChecker #(
  .ADDR_W  (ADDR_W),
  .DATA_W  (DATA_W),
  .NUM_SRC (NUM_SRC),
  .CNT_W   (CNT_W)
) uChk (
  .clk         (clk),
  .rstN        (rstN),
  .frameStrobe (frameStrobe),
  .evtIn       (evtIn),
  .regAddr     (regAddr),
  .regRdEn     (regRdEn),
  .regRdData   (regRdData),
  .irqOut      (irqOut),
  .enVec       (enVec),
  .pendVec     (pendVec),
  .frameCnt    (frameCnt)
);

// File: tb/irqFrameUnit_test.sv
module irqFrameUnit_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        frameStrobe = 1'b0;
  logic [6:0]  evtIn = '0;
  logic [7:0]  regAddr = '0;
  logic        regWrEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic        regRdEn = 1'b0;
  logic [31:0] regRdData;
  logic        irqOut;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  irqFrameUnit #(.CNT_W(4)) uut (
    .clk(clk), .rstN(rstN), .frameStrobe(frameStrobe), .evtIn(evtIn),
    .regAddr(regAddr), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdEn(regRdEn), .regRdData(regRdData), .irqOut(irqOut)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wrReg(input logic [7:0] a, input logic [31:0] d);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rdReg(input logic [7:0] a, output logic [31:0] v);
    regAddr = a; regRdEn = 1'b1;
    @(negedge clk);
    regRdEn = 1'b0;
    v = regRdData;
  endtask

  task automatic pulse(input logic [6:0] v);
    evtIn = v;
    @(negedge clk);
    evtIn = '0;
  endtask

  task automatic strobe();
    frameStrobe = 1'b1;
    @(negedge clk);
    frameStrobe = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic [31:0] en;
    logic [31:0] pd;
    int cnt;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    check("R1 irq", {31'b0, irqOut}, 0);
    rdReg(8'h00, v); check("R1 ctrl", v, 0);
    rdReg(8'h40, v); check("R1 count", v, 0);
    rdReg(8'h50, v); check("R1 match", v, 0);

    // R2 R3 R4 R6 sweep over the pulse-driven sources
    for (int k = 0; k < 7; k++) begin
      en = 32'h1 << (17 + 2*k);
      pd = 32'h1 << (16 + 2*k);
      pulse(7'(1 << k));
      rdReg(8'h00, v); check("R3 pending without enable", v, pd);
      check("R6 irq stays low when disabled", {31'b0, irqOut}, 0);
      wrReg(8'h00, en);
      @(negedge clk);
      check("R6 irq rises after enable", {31'b0, irqOut}, 1);
      rdReg(8'h00, v); check("R2 pair layout", v, en | pd);
      wrReg(8'h00, en);
      rdReg(8'h00, v); check("R4 zero keeps pending", v, en | pd);
      check("R6 irq held", {31'b0, irqOut}, 1);
      wrReg(8'h00, en | pd);
      @(negedge clk);
      check("R6 irq falls after clear", {31'b0, irqOut}, 0);
      rdReg(8'h00, v); check("R4 one clears pending", v, en);
      wrReg(8'h00, 32'h0);
      rdReg(8'h00, v); check("R4 enable cleared", v, 0);
    end

    // R2 low half
    wrReg(8'h00, 32'h0000_FFFF);
    rdReg(8'h00, v); check("R2 low bits zero", v, 0);

    // R5 set wins over same-cycle clear
    pulse(7'h08);
    evtIn = 7'h08; regAddr = 8'h00; regWrData = 32'h1 << 22; regWrEn = 1'b1;
    @(negedge clk);
    evtIn = '0; regWrEn = 1'b0;
    rdReg(8'h00, v); check("R5 set beats clear", v, 32'h1 << 22);
    pulse(7'h7F);
    evtIn = 7'h01; regAddr = 8'h00; regWrData = 32'h5555_0000; regWrEn = 1'b1;
    @(negedge clk);
    evtIn = '0; regWrEn = 1'b0;
    rdReg(8'h00, v); check("R5 only colliding bit survives", v, 32'h0001_0000);
    wrReg(8'h00, 32'h5555_0000);
    rdReg(8'h00, v); check("R4 all cleared", v, 0);

    // R7 counter sweep with wrap (4-bit counter); match=0 hits on wrap (R8)
    for (int i = 1; i <= 20; i++) begin
      strobe();
      rdReg(8'h40, v); check("R7 count", v, 32'(i % 16));
    end
    @(negedge clk); @(negedge clk);
    rdReg(8'h40, v); check("R7 count holds", v, 4);
    rdReg(8'h00, v); check("R8 match on wrap to zero", v, 32'h1 << 30);
    wrReg(8'h00, 32'h1 << 30);

    // R8 writing a match equal to the current count raises nothing
    wrReg(8'h50, 32'h4);
    rdReg(8'h50, v); check("R8 match readback", v, 4);
    rdReg(8'h00, v); check("R8 no event on equal write", v, 0);
    wrReg(8'h50, 32'h7);
    cnt = 4;
    for (int j = 0; j < 3; j++) begin
      strobe(); cnt++;
      rdReg(8'h00, v); check("R8 pending on reaching match", v, (cnt >= 7) ? (32'h1 << 30) : 0);
    end
    wrReg(8'h00, 32'h1 << 30);
    repeat (3) @(negedge clk);
    rdReg(8'h00, v); check("R8 no repeat while equal", v, 0);

    // R8 R6 frame-match interrupt through a full wrap
    wrReg(8'h00, 32'h1 << 31);
    for (int j = 0; j < 16; j++) begin
      strobe(); cnt = (cnt + 1) % 16;
      if (cnt == 7) begin
        @(negedge clk);
        check("R6 frame irq", {31'b0, irqOut}, 1);
      end else begin
        rdReg(8'h00, v); check("R8 no early match", v, 32'h1 << 31);
      end
    end
    wrReg(8'h00, 32'hC000_0000);
    @(negedge clk);
    check("R6 frame irq cleared", {31'b0, irqOut}, 0);

    // R8 only low CNT_W bits stored
    wrReg(8'h50, 32'hFFFF_FFF3);
    rdReg(8'h50, v); check("R8 match width", v, 3);

    // R9 unused offsets
    wrReg(8'h10, 32'hFFFF_FFFF);
    wrReg(8'h60, 32'hFFFF_FFFF);
    wrReg(8'h04, 32'hFFFF_FFFF);
    wrReg(8'h51, 32'hFFFF_FFFF);
    wrReg(8'h40, 32'hFFFF_FFFF);
    wrReg(8'hF0, 32'hFFFF_FFFF);
    rdReg(8'h00, v); check("R9 ctrl untouched", v, 32'h1 << 31);
    rdReg(8'h40, v); check("R9 count untouched", v, 7);
    rdReg(8'h50, v); check("R9 match untouched", v, 3);
    rdReg(8'h10, v); check("R9 read 0x10", v, 0);
    rdReg(8'h04, v); check("R9 read 0x04", v, 0);
    rdReg(8'h41, v); check("R9 read 0x41", v, 0);
    rdReg(8'hF0, v); check("R9 read 0xF0", v, 0);

    // R10 read data timing and hold
    rdReg(8'h40, v); check("R10 read", v, 7);
    regAddr = 8'h00;
    strobe();
    @(negedge clk);
    check("R10 rdData holds", regRdData, 7);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule